// File: doc/BRIEF.md
# Cascadable Program Counter Slice Chain

This block is a chain of byte-wide counter slices that together hold an instruction address. Each slice is an 8-bit register that can be cleared, loaded from a shared byte bus, or advanced by one. A fixed priority decides between these actions: clearing beats loading, and loading beats counting. The slices are linked through their count enables. A slice produces an active-low carry enable that drives the count enable of the next, more significant slice. With the default of three slices the chain forms a 24-bit address that moves forward by exactly one on every enabled rising edge.

All controls are active low and act at the clock edge. The reset line is shared by all slices. Each slice has its own load strobe, so software or a sequencer can write the address one byte at a time through the common data input. The count enable drives the least significant slice only. The carry enable of the most significant slice comes out as a wrap indication. It is low in the cycle where the whole address is about to roll over to zero.

Top module: `pc_chain`

## Requirements
- R1: When rstN is low at a rising edge, every slice becomes 0x00 after that edge, whatever loadN, cntEnN and dataIn are.
- R2: When rstN is high and loadN[k] is low at a rising edge, slice k (address bits 8k+7 down to 8k) takes the value of dataIn after that edge. Slices whose load bit is high are not written.
- R3: When rstN is high, loadN[0] is high and cntEnN is low at a rising edge, the low byte of the address grows by one.
- R4: When rstN is high, all loadN bits are high and cntEnN is high, the address keeps its value across the edge.
- R5: A counting slice that holds 0xFF becomes 0x00 and never 0x01. Bit i of a counting slice toggles only when all of its lower bits are 1.
- R6: wrapN is low exactly when rstN is high, no loadN bit is low, cntEnN is low and the address is all ones. Otherwise it is high.
- R7: A slice that is being loaded sends no carry to the next slice. The next slice advances only if no slice below it is loaded, cntEnN is low, and every slice below it holds 0xFF.
- R8: With no load and no reset, each enabled edge adds exactly one to the full address, modulo 2^24. This includes the step from 0xFFFFFF to 0x000000.
- R9: 256 consecutive enabled edges return the low slice to its start value and advance the next slice exactly once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Synchronous clear of all slices, active low |
| loadN | input | NUM_SLICES | Per-slice parallel load strobe, active low, bit k for slice k |
| cntEnN | input | 1 | Count enable of the least significant slice, active low |
| dataIn | input | SLICE_W | Shared byte bus written into the loaded slices |
| addr | output | SLICE_W*NUM_SLICES | Current address, slice 0 in the low bits |
| wrapN | output | 1 | Carry enable out of the top slice, active low |

## Verification
The hardest conditions to reach from the ports are the ones where a carry meets another control in the same cycle. One is a slice that sits at 0xFF and is loaded while counting is enabled. Another is an upper slice being loaded just as a carry arrives from below. The bench reaches them by first writing 0xFF into every slice in one edge, with all load strobes asserted together. It then applies every combination of reset, the three load strobes and the count enable. It also writes the address one byte at a time to just below the 16-bit and 24-bit boundaries, then counts across them and across the full wrap to zero.

// File: rtl/pc_chain_pkg.sv
package pc_chain_pkg;

  // One-hot-or-idle command from the control decoder to a slice datapath.
  typedef struct packed {
    logic clear;
    logic load;
    logic step;
  } sliceCmd_t;

endpackage

// File: rtl/pc_slice_ctrl.sv
module pc_slice_ctrl
  import pc_chain_pkg::*;
(
  input  logic      rstN,
  input  logic      loadN,
  input  logic      cntEnN,
  output sliceCmd_t cmd
);

  // Fixed priority: clear over load over step (R1, R2, R3).
  always_comb begin
    cmd       = '0;
    cmd.clear = ~rstN;
    cmd.load  = rstN & ~loadN;
    cmd.step  = rstN & loadN & ~cntEnN;
  end

endmodule

// File: rtl/pc_slice_dp.sv
module pc_slice_dp
  import pc_chain_pkg::*;
#(
  parameter int SLICE_W = 8
) (
  input  logic               clk,
  input  sliceCmd_t          cmd,
  input  logic [SLICE_W-1:0] dataIn,
  output logic [SLICE_W-1:0] sliceVal,
  output logic               carryN
);

  logic [SLICE_W:0]   onesBelow;
  logic [SLICE_W-1:0] incVal;

  assign onesBelow[0] = 1'b1;

  // Bit i toggles only when every lower bit is one (R5).
  for (genvar i = 0; i < SLICE_W; i++) begin : g_toggle
    assign onesBelow[i+1] = onesBelow[i] & sliceVal[i];
    assign incVal[i]      = sliceVal[i] ^ onesBelow[i];
  end

  // Carry only from a slice that is really stepping (R6, R7).
  assign carryN = ~(cmd.step & onesBelow[SLICE_W]);

  always_ff @(posedge clk) begin
    if (cmd.clear)     sliceVal <= '0;
    else if (cmd.load) sliceVal <= dataIn;
    else if (cmd.step) sliceVal <= incVal;
  end

endmodule

// File: rtl/pc_slice.sv
module pc_slice
  import pc_chain_pkg::*;
#(
  parameter int SLICE_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               loadN,
  input  logic               cntEnN,
  input  logic [SLICE_W-1:0] dataIn,
  output logic [SLICE_W-1:0] sliceVal,
  output logic               carryN
);

  sliceCmd_t cmd;

  pc_slice_ctrl u_ctrl (
    .rstN   (rstN),
    .loadN  (loadN),
    .cntEnN (cntEnN),
    .cmd    (cmd)
  );

  pc_slice_dp #(.SLICE_W(SLICE_W)) u_dp (
    .clk      (clk),
    .cmd      (cmd),
    .dataIn   (dataIn),
    .sliceVal (sliceVal),
    .carryN   (carryN)
  );

endmodule

// File: rtl/pc_chain.sv
module pc_chain #(
  parameter int SLICE_W    = 8,
  parameter int NUM_SLICES = 3,
  localparam int ADDR_W    = SLICE_W * NUM_SLICES
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [NUM_SLICES-1:0] loadN,
  input  logic                  cntEnN,
  input  logic [SLICE_W-1:0]    dataIn,
  output logic [ADDR_W-1:0]     addr,
  output logic                  wrapN
);

  // enChainN[k] is the count enable of slice k; enChainN[k+1] its carry out.
  logic [NUM_SLICES:0] enChainN;

  assign enChainN[0] = cntEnN;

  for (genvar k = 0; k < NUM_SLICES; k++) begin : g_slice
    pc_slice #(.SLICE_W(SLICE_W)) u_slice (
      .clk      (clk),
      .rstN     (rstN),
      .loadN    (loadN[k]),
      .cntEnN   (enChainN[k]),
      .dataIn   (dataIn),
      .sliceVal (addr[k*SLICE_W +: SLICE_W]),
      .carryN   (enChainN[k+1])
    );
  end

  assign wrapN = enChainN[NUM_SLICES];

endmodule

// File: rtl/pc_chain_chk.sv
module pc_chain_chk #(
  parameter int SLICE_W    = 8,
  parameter int NUM_SLICES = 3,
  localparam int ADDR_W    = SLICE_W * NUM_SLICES
) (
  input logic                  clk,
  input logic                  rstN,
  input logic [NUM_SLICES-1:0] loadN,
  input logic                  cntEnN,
  input logic [SLICE_W-1:0]    dataIn,
  input logic [ADDR_W-1:0]     addr,
  input logic                  wrapN
);

  AST_RESET_CLEARS: assert property (@(posedge clk)
    !rstN |=> addr == '0); // R1

  AST_LOAD_LOW: assert property (@(posedge clk) disable iff (!rstN)
    !loadN[0] |=> addr[SLICE_W-1:0] == $past(dataIn)); // R2

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (&loadN && cntEnN) |=> $stable(addr)); // R4

  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rstN)
    (&loadN && !cntEnN) |=> addr == $past(addr) + ADDR_W'(1)); // R8

  AST_LOW_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (loadN[0] && !cntEnN && addr[SLICE_W-1:0] == '1) |=> addr[SLICE_W-1:0] == '0); // R5

  AST_WRAP_OUT: assert property (@(posedge clk) disable iff (!rstN)
    !wrapN |-> (&loadN && !cntEnN && &addr)); // R6

endmodule

bind pc_chain pc_chain_chk #(.SLICE_W(SLICE_W), .NUM_SLICES(NUM_SLICES)) u_chk (.*);

// File: tb/test_pc_chain.sv
module test_pc_chain;

  localparam int CLK_PERIOD = 10;
  localparam int SW = 8;
  localparam int NS = 3;
  localparam int AW = SW * NS;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [NS-1:0] loadN = '1;
  logic          cntEnN = 1'b1;
  logic [SW-1:0] dataIn = '0;
  logic [AW-1:0] addr;
  logic          wrapN;

  int checkCount = 0;
  int failCount = 0;
  logic [AW-1:0] expAddr = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pc_chain #(.SLICE_W(SW), .NUM_SLICES(NS)) i_pc_chain (
    .clk(clk), .rstN(rstN), .loadN(loadN), .cntEnN(cntEnN),
    .dataIn(dataIn), .addr(addr), .wrapN(wrapN)
  );

  task automatic check(input string tag, input logic [AW-1:0] act, input logic [AW-1:0] exp);
    checkCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Arithmetic model: per-slice carry ripples only through stepping slices.
  task automatic model(input logic r, input logic [NS-1:0] l, input logic c,
                       input logic [SW-1:0] d, output logic [AW-1:0] nxt, output logic wN);
    logic carry;
    carry = r & ~c;
    nxt = expAddr;
    for (int k = 0; k < NS; k++) begin
      if (!r) nxt[k*SW +: SW] = '0;
      else if (!l[k]) begin
        nxt[k*SW +: SW] = d;
        carry = 1'b0;
      end else if (carry) begin
        nxt[k*SW +: SW] = expAddr[k*SW +: SW] + SW'(1);
        carry = (expAddr[k*SW +: SW] == '1);
      end else carry = 1'b0;
    end
    wN = ~carry;
  endtask

  task automatic drive(input logic r, input logic [NS-1:0] l, input logic c,
                       input logic [SW-1:0] d, input string tag);
    logic [AW-1:0] nxt;
    logic wN;
    @(negedge clk);
    rstN = r; loadN = l; cntEnN = c; dataIn = d;
    model(r, l, c, d, nxt, wN);
    #1;
    check("R6 wrapN", AW'(wrapN), AW'(wN));
    @(posedge clk);
    #1;
    check(tag, addr, nxt);
    expAddr = nxt;
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    failCount++;
    $display("FAIL R8 watchdog actual=hung expected=finished");
    finishRun();
  end

  initial begin
    logic [SW-1:0] preVals [2];
    int upperMoves;
    logic [SW-1:0] lastUpper;
    preVals[0] = 8'hFF;
    preVals[1] = 8'h5A;

    // R1: reset state
    drive(1'b0, '1, 1'b1, 8'h00, "R1");
    drive(1'b0, 3'b000, 1'b0, 8'h77, "R1");

    // Priority sweep over every control combination from two preloads.
    foreach (preVals[p]) begin
      for (int combo = 0; combo < 32; combo++) begin
        string tag;
        drive(1'b1, 3'b000, 1'b1, preVals[p], "R2");
        if (!combo[4]) tag = "R1";
        else if (combo[3:1] != 3'b111) tag = "R7";
        else if (!combo[0]) tag = "R3";
        else tag = "R4";
        drive(combo[4], combo[3:1], combo[0], 8'h3C, tag);
      end
    end

    // Byte-wise load to 0x01FFF0, count across the 16-bit boundary.
    drive(1'b1, 3'b011, 1'b1, 8'h01, "R2");
    drive(1'b1, 3'b101, 1'b1, 8'hFF, "R2");
    drive(1'b1, 3'b110, 1'b1, 8'hF0, "R2");
    for (int i = 0; i < 300; i++) drive(1'b1, '1, 1'b0, 8'h00, "R8");

    // Hold with every control idle while data toggles.
    for (int i = 0; i < 5; i++) drive(1'b1, '1, 1'b1, SW'(i * 37), "R4");

    // Full wrap from 0xFFFFF8 through zero.
    drive(1'b1, 3'b000, 1'b1, 8'hFF, "R2");
    drive(1'b1, 3'b110, 1'b1, 8'hF8, "R2");
    for (int i = 0; i < 16; i++) drive(1'b1, '1, 1'b0, 8'h00, "R5");

    // R9: 256 steps from 0x0000A5, one advance of the next slice.
    drive(1'b1, 3'b000, 1'b1, 8'h00, "R2");
    drive(1'b1, 3'b110, 1'b1, 8'hA5, "R2");
    upperMoves = 0;
    lastUpper = addr[2*SW-1:SW];
    for (int i = 0; i < 256; i++) begin
      drive(1'b1, '1, 1'b0, 8'h00, "R9");
      if (addr[2*SW-1:SW] != lastUpper) upperMoves++;
      lastUpper = addr[2*SW-1:SW];
    end
    check("R9 carry count", AW'(upperMoves), AW'(1));
    check("R9 low byte", AW'(addr[SW-1:0]), AW'(8'hA5));

    finishRun();
  end

endmodule